// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache with Selectable Write Policies

This block is a small data cache for an 8-bit byte address space (256 bytes). It holds 64 bytes as eight 8-byte blocks arranged in four sets of two ways. A processor issues one access at a time on the request port. A read hit completes in the request cycle. Every other access stalls the processor, with ready held low, while the block talks to the next-level memory over a block-wide port that carries a byte-enable mask.

Two static configuration inputs select the policy. `cfg_wb` picks write-back (1) or write-through (0) handling of stores. `cfg_walloc` picks allocate (1) or no-allocate (0) on write misses. Each set keeps one LRU bit. An invalid way is always filled before a valid way is replaced. A dirty victim is written back in full before the new block is read.

A controller in state `ST_IDLE` compares both ways of the indexed set combinationally.
- A read hit, or a write hit in write-back mode, completes at once.
- A write hit in write-through mode, and a write miss with no-allocate, move to `ST_THRU`. That state issues a single byte write to memory, and the access completes on `mem_done`.
- Any other miss moves to `ST_EVICT` if the victim is valid and dirty, and to `ST_FILL` otherwise. `ST_EVICT` moves on to `ST_FILL` on `mem_done`.
- `ST_FILL` installs the block on `mem_done` and returns to `ST_IDLE`. There the still-held request finishes as a hit on the new block.

Top module: `sa_cache`

## Requirements
- R1: After reset every way is invalid and clean. With no request, `cpu_ready` and `mem_req` are 0. An access to a block that was resident before the reset misses and fetches from memory.
- R2: A read hit asserts `cpu_ready` and `cpu_hit` in the request cycle. `cpu_rdata` returns the byte selected by address bits [2:0] within the block. There is no memory traffic.
- R3: A read miss performs one block read (`mem_we`=0) at the aligned address {tag, index, 3'b000}. The tag is address bits [7:5] and the index is bits [4:3]. The access then completes with `cpu_hit`=0 and the addressed byte.
- R4: Two blocks with the same index and different tags can be resident together, and both hit.
- R5: The victim is an invalid way if one exists. Otherwise it is the way used less recently in that set, where a hit or a completed access counts as a use.
- R6: In write-back mode a write hit updates the cached byte and marks the block dirty, with no memory traffic. It completes in the request cycle with `cpu_hit`=1.
- R7: When a dirty victim is replaced, one full block write of its data to its own aligned address (`mem_be`=8'hFF) precedes the block read of the new block.
- R8: In write-through mode every store issues one memory write. That write has `mem_be` = 1 << address[2:0] and carries the byte in lane address[2:0] of `mem_wdata`. On a hit the cached copy is updated too, and the block is never marked dirty.
- R9: A write miss with allocate reads the whole block first and then merges the byte as a write hit. A later read hits and returns the new byte.
- R10: A write miss with no-allocate issues only the single byte write of R8 and completes with `cpu_hit`=0. The cache contents are unchanged, so a later read of that address misses.
- R11: Replacing a clean victim causes no memory write.
- R12: Once raised, `mem_req` stays high with a stable `mem_addr` until `mem_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wb | input | 1 | 1 selects write-back, 0 selects write-through |
| cfg_walloc | input | 1 | 1 allocates on write miss, 0 bypasses the arrays |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 for a byte store, 0 for a load |
| cpu_addr | input | 8 | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_rdata | output | 8 | Load byte, valid with `cpu_ready` on a load |
| cpu_hit | output | 1 | Access finished without a miss, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle pulse marking completion of the access |
| mem_req | output | 1 | Next-level request |
| mem_we | output | 1 | 1 write, 0 block read |
| mem_addr | output | 8 | Block-aligned address |
| mem_be | output | 8 | Byte enables of a write |
| mem_wdata | output | 64 | Write data, byte n in bits [8n+7:8n] |
| mem_rdata | input | 64 | Block read data, valid with `mem_done` |
| mem_done | input | 1 | One-cycle completion of the request |

## Verification
A write hit in write-back mode sets the dirty bit and moves the LRU bit to the other way in the same cycle. The bench provokes this by writing one block of a full set and then touching the other way. The following miss must therefore pick the dirty block as victim, and the bench judges this by the transfer log: a full-block write at the dirty block's address, then the fill read. A later read must also return the merged byte from memory. The fill completion and the byte merge of an allocating write miss also meet in back-to-back cycles. They are judged by the value a following read hit returns.

// File: rtl/sac_pkg.sv
package sac_pkg;
    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_THRU
    } sac_state_t;
endpackage

// File: rtl/sac_tags.sv
module sac_tags #(
    parameter int IDX_W = 2,
    parameter int TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wb,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    input  logic             fill_en,
    input  logic             touch_en,
    input  logic             dirty_set_en,
    output logic [1:0]       hit_vec,
    output logic             hit_way,
    output logic             vic_way,
    output logic             vic_valid,
    output logic             vic_dirty,
    output logic [TAG_W-1:0] vic_tag
);
    localparam int SETS = 1 << IDX_W;

    logic             valid_q [sac_pkg::WAYS][SETS];
    logic             dirty_q [sac_pkg::WAYS][SETS];
    logic [TAG_W-1:0] tag_q   [sac_pkg::WAYS][SETS];
    logic             lru_q   [SETS];

    for (genvar w = 0; w < sac_pkg::WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid_q[w][idx] && (tag_q[w][idx] == tag);
    end

    assign hit_way = hit_vec[1];

    always_comb begin
        if (!valid_q[0][idx])      vic_way = 1'b0;
        else if (!valid_q[1][idx]) vic_way = 1'b1;
        else                       vic_way = lru_q[idx];
        vic_valid = valid_q[vic_way][idx];
        vic_dirty = dirty_q[vic_way][idx];
        vic_tag   = tag_q[vic_way][idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                lru_q[s] <= 1'b0;
                for (int w = 0; w < sac_pkg::WAYS; w++) begin
                    valid_q[w][s] <= 1'b0;
                    dirty_q[w][s] <= 1'b0;
                    tag_q[w][s]   <= '0;
                end
            end
        end else begin
            if (fill_en) begin
                valid_q[vic_way][idx] <= 1'b1;
                dirty_q[vic_way][idx] <= 1'b0;
                tag_q[vic_way][idx]   <= tag;
            end
            if (touch_en) begin
                lru_q[idx] <= ~hit_way;
            end
            if (dirty_set_en) begin
                dirty_q[hit_way][idx] <= 1'b1;
            end
        end
    end

    // R4
    hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R8
    no_dirty_in_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_set_en |-> cfg_wb);

    // R3
    fill_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> valid_q[$past(vic_way)][$past(idx)]);
endmodule

// File: rtl/sac_data.sv
module sac_data #(
    parameter int IDX_W = 2,
    parameter int OFF_W = 3
) (
    input  logic                                         clk,
    input  logic [IDX_W-1:0]                             idx,
    input  logic [OFF_W-1:0]                             off,
    input  logic                                         fill_en,
    input  logic                                         fill_way,
    input  logic [(8<<OFF_W)-1:0]                        fill_blk,
    input  logic                                         bwr_en,
    input  logic                                         bwr_way,
    input  logic [7:0]                                   bwr_byte,
    output logic [sac_pkg::WAYS-1:0][(8<<OFF_W)-1:0]     rd_blk
);
    localparam int SETS  = 1 << IDX_W;
    localparam int BLK_W = 8 << OFF_W;

    for (genvar w = 0; w < sac_pkg::WAYS; w++) begin : g_way
        logic [BLK_W-1:0] arr [SETS];

        always_ff @(posedge clk) begin
            if (fill_en && (fill_way == 1'(w))) begin
                arr[idx] <= fill_blk;
            end else if (bwr_en && (bwr_way == 1'(w))) begin
                arr[idx][{off, 3'b000} +: 8] <= bwr_byte;
            end
        end

        assign rd_blk[w] = arr[idx];
    end
endmodule

// File: rtl/sac_ctrl.sv
module sac_ctrl
    import sac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_req,
    input  logic       cpu_we,
    input  logic       cfg_wb,
    input  logic       cfg_walloc,
    input  logic       hit_any,
    input  logic       vic_valid,
    input  logic       vic_dirty,
    input  logic       mem_done,
    output sac_state_t state,
    output logic       cpu_ready,
    output logic       cpu_hit,
    output logic       mem_req,
    output logic       mem_we,
    output logic       fill_en,
    output logic       touch_en,
    output logic       bwr_en,
    output logic       dirty_set_en
);
    sac_state_t nxt;
    logic       missed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            missed_q <= 1'b0;
        end else begin
            state <= nxt;
            if (cpu_ready) begin
                missed_q <= 1'b0;
            end else if (state == ST_IDLE && cpu_req && !hit_any) begin
                missed_q <= 1'b1;
            end
        end
    end

    always_comb begin
        nxt          = state;
        cpu_ready    = 1'b0;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        fill_en      = 1'b0;
        touch_en     = 1'b0;
        bwr_en       = 1'b0;
        dirty_set_en = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (hit_any) begin
                        touch_en = 1'b1;
                        if (!cpu_we) begin
                            cpu_ready = 1'b1;
                        end else begin
                            bwr_en = 1'b1;
                            if (cfg_wb) begin
                                dirty_set_en = 1'b1;
                                cpu_ready    = 1'b1;
                            end else begin
                                nxt = ST_THRU;
                            end
                        end
                    end else if (cpu_we && !cfg_walloc) begin
                        nxt = ST_THRU;
                    end else if (vic_valid && vic_dirty) begin
                        nxt = ST_EVICT;
                    end else begin
                        nxt = ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_done) nxt = ST_FILL;
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_done) begin
                    fill_en = 1'b1;
                    nxt     = ST_IDLE;
                end
            end
            ST_THRU: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_done) begin
                    cpu_ready = 1'b1;
                    nxt       = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
        cpu_hit = cpu_ready && !missed_q;
    end

    // R2
    ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=> mem_req);

    // R7
    evict_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVICT && mem_done) |=> (mem_req && !mem_we));
endmodule

// File: rtl/sa_cache.sv
module sa_cache
    import sac_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int OFF_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wb,
    input  logic                     cfg_walloc,
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [7:0]               cpu_wdata,
    output logic [7:0]               cpu_rdata,
    output logic                     cpu_hit,
    output logic                     cpu_ready,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [(1<<OFF_W)-1:0]    mem_be,
    output logic [(8<<OFF_W)-1:0]    mem_wdata,
    input  logic [(8<<OFF_W)-1:0]    mem_rdata,
    input  logic                     mem_done
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int BYTES = 1 << OFF_W;
    localparam int BLK_W = 8 * BYTES;

    logic [TAG_W-1:0] tag;
    logic [IDX_W-1:0] idx;
    logic [OFF_W-1:0] off;

    assign off = cpu_addr[OFF_W-1:0];
    assign idx = cpu_addr[OFF_W +: IDX_W];
    assign tag = cpu_addr[ADDR_W-1 -: TAG_W];

    logic [1:0]       hit_vec;
    logic             hit_way, vic_way, vic_valid, vic_dirty;
    logic [TAG_W-1:0] vic_tag;
    logic             fill_en, touch_en, bwr_en, dirty_set_en;
    sac_state_t       state;
    logic [WAYS-1:0][BLK_W-1:0] rd_blk;
    logic [BLK_W-1:0] hit_blk;

    sac_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wb       (cfg_wb),
        .idx          (idx),
        .tag          (tag),
        .fill_en      (fill_en),
        .touch_en     (touch_en),
        .dirty_set_en (dirty_set_en),
        .hit_vec      (hit_vec),
        .hit_way      (hit_way),
        .vic_way      (vic_way),
        .vic_valid    (vic_valid),
        .vic_dirty    (vic_dirty),
        .vic_tag      (vic_tag)
    );

    sac_data #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
        .clk      (clk),
        .idx      (idx),
        .off      (off),
        .fill_en  (fill_en),
        .fill_way (vic_way),
        .fill_blk (mem_rdata),
        .bwr_en   (bwr_en),
        .bwr_way  (hit_way),
        .bwr_byte (cpu_wdata),
        .rd_blk   (rd_blk)
    );

    sac_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cfg_wb       (cfg_wb),
        .cfg_walloc   (cfg_walloc),
        .hit_any      (|hit_vec),
        .vic_valid    (vic_valid),
        .vic_dirty    (vic_dirty),
        .mem_done     (mem_done),
        .state        (state),
        .cpu_ready    (cpu_ready),
        .cpu_hit      (cpu_hit),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .fill_en      (fill_en),
        .touch_en     (touch_en),
        .bwr_en       (bwr_en),
        .dirty_set_en (dirty_set_en)
    );

    assign hit_blk   = rd_blk[hit_way];
    assign cpu_rdata = hit_blk[{off, 3'b000} +: 8];

    always_comb begin
        if (state == ST_EVICT) begin
            mem_addr  = {vic_tag, idx, {OFF_W{1'b0}}};
            mem_wdata = rd_blk[vic_way];
            mem_be    = '1;
        end else begin
            mem_addr  = {tag, idx, {OFF_W{1'b0}}};
            mem_wdata = {BYTES{cpu_wdata}};
            mem_be    = (state == ST_THRU) ? (BYTES'(1) << off) : '0;
        end
    end

    // R12
    mem_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=> $stable(mem_addr));
endmodule

// File: tb/sim_sa_cache.sv
`timescale 1ns/1ps
module sim_sa_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wb = 1'b1, cfg_walloc = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0, cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_hit, cpu_ready;
    logic        mem_req, mem_we;
    logic [7:0]  mem_addr, mem_be;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        mem_done = 1'b0;

    always #2 clk = ~clk;

    sa_cache u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wb(cfg_wb), .cfg_walloc(cfg_walloc),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done)
    );

    // next-level memory model with a fixed three-cycle latency
    logic [7:0]  mem_img [256];
    logic        mem_init = 1'b0;
    int          lat = 0, n_rd = 0, n_wr = 0, n_tx = 0, viol = 0;
    logic        pend = 1'b0;
    logic [7:0]  pend_addr = '0;
    logic        log_we   [64];
    logic [7:0]  log_addr [64];
    logic [7:0]  log_be   [64];
    logic [63:0] log_wd   [64];

    always @(posedge clk) begin
        if (!mem_init) begin
            for (int i = 0; i < 256; i++) mem_img[i] <= 8'(i) ^ 8'h5A;
            mem_init <= 1'b1;
        end
        mem_done <= 1'b0;
        if (pend && (!mem_req || mem_addr != pend_addr)) viol <= viol + 1;
        if (mem_req && !mem_done) begin
            if (lat == 2) begin
                lat      <= 0;
                pend     <= 1'b0;
                mem_done <= 1'b1;
                log_we[n_tx % 64]   <= mem_we;
                log_addr[n_tx % 64] <= mem_addr;
                log_be[n_tx % 64]   <= mem_be;
                log_wd[n_tx % 64]   <= mem_wdata;
                n_tx <= n_tx + 1;
                if (mem_we) begin
                    for (int b = 0; b < 8; b++)
                        if (mem_be[b]) mem_img[mem_addr + 8'(b)] <= mem_wdata[b*8 +: 8];
                    n_wr <= n_wr + 1;
                end else begin
                    for (int b = 0; b < 8; b++)
                        mem_rdata[b*8 +: 8] <= mem_img[mem_addr + 8'(b)];
                    n_rd <= n_rd + 1;
                end
            end else begin
                lat       <= lat + 1;
                pend      <= 1'b1;
                pend_addr <= mem_addr;
            end
        end
    end

    int n_chk = 0, n_err = 0;
    logic [7:0] ref_mem [256];

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [7:0] addr, input logic [7:0] wd,
                          output logic [7:0] rd, output logic ht);
        int cyc = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        #1;
        while (!cpu_ready && cyc < 200) begin
            @(negedge clk); #1; cyc++;
        end
        if (!cpu_ready) begin
            n_chk++; n_err++;
            $display("FAIL R12 access hung actual=0 expected=1");
        end
        rd = cpu_rdata; ht = cpu_hit;
        if (we) ref_mem[addr] = wd;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    typedef struct packed {
        logic       wb;
        logic       al;
        logic       we;
        logic [7:0] addr;
        logic [7:0] wd;
        logic       hit;
        logic [1:0] nrd;
        logic [1:0] nwr;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b0, 8'h08, 8'h00, 1'b0, 2'd1, 2'd0, 8'd3},  // R3 cold miss
        '{1'b1, 1'b1, 1'b0, 8'h0B, 8'h00, 1'b1, 2'd0, 2'd0, 8'd2},  // R2 hit
        '{1'b1, 1'b1, 1'b0, 8'h28, 8'h00, 1'b0, 2'd1, 2'd0, 8'd4},  // R4 second way
        '{1'b1, 1'b1, 1'b0, 8'h0C, 8'h00, 1'b1, 2'd0, 2'd0, 8'd4},  // R4 both resident
        '{1'b1, 1'b1, 1'b1, 8'h2A, 8'h11, 1'b1, 2'd0, 2'd0, 8'd6},  // R6 write-back hit
        '{1'b1, 1'b1, 1'b0, 8'h48, 8'h00, 1'b0, 2'd1, 2'd0, 8'd5},  // R5 LRU clean victim
        '{1'b1, 1'b1, 1'b0, 8'h2A, 8'h00, 1'b1, 2'd0, 2'd0, 8'd6},  // R6 merged byte
        '{1'b1, 1'b1, 1'b0, 8'h68, 8'h00, 1'b0, 2'd1, 2'd0, 8'd5},  // R5
        '{1'b1, 1'b1, 1'b0, 8'h08, 8'h00, 1'b0, 2'd1, 2'd1, 8'd7},  // R7 dirty victim
        '{1'b1, 1'b1, 1'b0, 8'h2A, 8'h00, 1'b0, 2'd1, 2'd0, 8'd7},  // R7 written back data
        '{1'b1, 1'b1, 1'b1, 8'h90, 8'h44, 1'b0, 2'd1, 2'd0, 8'd9},  // R9 allocate
        '{1'b1, 1'b1, 1'b0, 8'h90, 8'h00, 1'b1, 2'd0, 2'd0, 8'd9},  // R9 merged
        '{1'b0, 1'b1, 1'b1, 8'h0D, 8'h22, 1'b1, 2'd0, 2'd1, 8'd8},  // R8 through hit
        '{1'b0, 1'b1, 1'b0, 8'h0D, 8'h00, 1'b1, 2'd0, 2'd0, 8'd8},  // R8 cache updated
        '{1'b1, 1'b0, 1'b1, 8'hB0, 8'h33, 1'b0, 2'd0, 2'd1, 8'd10}, // R10 bypass
        '{1'b1, 1'b0, 1'b0, 8'h90, 8'h00, 1'b1, 2'd0, 2'd0, 8'd10}, // R10 set unchanged
        '{1'b1, 1'b0, 1'b0, 8'hB0, 8'h00, 1'b0, 2'd1, 2'd0, 8'd10}, // R10 later read misses
        '{1'b0, 1'b0, 1'b1, 8'hF8, 8'h55, 1'b0, 2'd0, 2'd1, 8'd10}, // R10 through bypass
        '{1'b0, 1'b0, 1'b0, 8'hF8, 8'h00, 1'b0, 2'd1, 2'd0, 8'd10}, // R10
        '{1'b0, 1'b0, 1'b0, 8'h48, 8'h00, 1'b0, 2'd1, 2'd0, 8'd11}  // R11 clean victim
    };

    initial begin
        #400000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic       ht;
        int         r0, w0, k;
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(cpu_ready == 1'b0, "R1 ready idle", 64'(cpu_ready), 64'd0);
        chk(mem_req == 1'b0, "R1 mem_req idle", 64'(mem_req), 64'd0);

        for (int i = 0; i < NV; i++) begin
            cfg_wb = VECS[i].wb; cfg_walloc = VECS[i].al;
            r0 = n_rd; w0 = n_wr;
            access(VECS[i].we, VECS[i].addr, VECS[i].wd, rd, ht);
            chk(ht == VECS[i].hit, $sformatf("R%0d vec %0d hit", VECS[i].req, i), 64'(ht), 64'(VECS[i].hit));
            chk(n_rd - r0 == int'(VECS[i].nrd), $sformatf("R%0d vec %0d reads", VECS[i].req, i),
                64'(n_rd - r0), 64'(VECS[i].nrd));
            chk(n_wr - w0 == int'(VECS[i].nwr), $sformatf("R%0d vec %0d writes", VECS[i].req, i),
                64'(n_wr - w0), 64'(VECS[i].nwr));
            if (!VECS[i].we)
                chk(rd == ref_mem[VECS[i].addr], $sformatf("R%0d vec %0d data", VECS[i].req, i),
                    64'(rd), 64'(ref_mem[VECS[i].addr]));
        end

        // R8 and R10: byte lane and enable of a single-byte store
        cfg_wb = 1'b0; cfg_walloc = 1'b0;
        k = n_tx;
        access(1'b1, 8'h13, 8'h66, rd, ht);
        chk(log_we[k % 64] == 1'b1, "R8 lane write", 64'(log_we[k % 64]), 64'd1);
        chk(log_be[k % 64] == 8'h08, "R8 lane enable", 64'(log_be[k % 64]), 64'h08);
        chk(log_addr[k % 64] == 8'h10, "R10 lane addr", 64'(log_addr[k % 64]), 64'h10);
        chk(log_wd[k % 64][31:24] == 8'h66, "R8 lane data", 64'(log_wd[k % 64][31:24]), 64'h66);

        // R7: dirty block leaves memory before the fill of the new one
        cfg_wb = 1'b1; cfg_walloc = 1'b1;
        access(1'b0, 8'h00, 8'h00, rd, ht);
        access(1'b1, 8'h01, 8'h77, rd, ht);
        access(1'b0, 8'h20, 8'h00, rd, ht);
        k = n_tx;
        access(1'b0, 8'h40, 8'h00, rd, ht);
        chk(n_tx - k == 2, "R7 transfer count", 64'(n_tx - k), 64'd2);
        chk(log_we[k % 64] == 1'b1 && log_addr[k % 64] == 8'h00 && log_be[k % 64] == 8'hFF,
            "R7 writeback first", {log_we[k % 64], log_addr[k % 64]}, {1'b1, 8'h00});
        chk(log_we[(k+1) % 64] == 1'b0 && log_addr[(k+1) % 64] == 8'h40,
            "R7 fill second", {log_we[(k+1) % 64], log_addr[(k+1) % 64]}, {1'b0, 8'h40});
        r0 = n_rd; w0 = n_wr;
        access(1'b0, 8'h01, 8'h00, rd, ht);
        chk(rd == 8'h77, "R7 data from memory", 64'(rd), 64'h77);
        chk(n_wr == w0 && n_rd == r0 + 1, "R11 clean replace", 64'(n_wr - w0), 64'd0);

        // R1: a reset drops resident blocks
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        r0 = n_rd;
        access(1'b0, 8'h40, 8'h00, rd, ht);
        chk(ht == 1'b0, "R1 miss after reset", 64'(ht), 64'd0);
        chk(n_rd == r0 + 1, "R1 refetch after reset", 64'(n_rd - r0), 64'd1);
        chk(rd == ref_mem[8'h40], "R1 data after reset", 64'(rd), 64'(ref_mem[8'h40]));

        repeat (2) @(negedge clk);
        chk(viol == 0, "R12 request held stable", 64'(viol), 64'd0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule